// File: doc/BRIEF.md
# Prioritized Interrupt Controller With Acknowledge

This block gathers up to 32 interrupt request lines and presents one 3-bit requested level to the processor core. Each source has a programmable level from 1 to 7, a priority from 0 to 7 within its level, and a mask bit. A source whose control word is still zero, its reset value, has level 0. Such a source is disabled and takes no part in any arbitration. Levels 1 to 6 follow the request line while it is held. A level-7 source is edge-triggered instead. A rising edge on its request is caught in a sticky flag, and the processor's own level mask can never hold that flag off.

Software reaches the controller over a simple register bus. The bus carries the source mask, a read/write force register that can raise any source, the level-7 edge flags and a wakeup mask level. It also carries eight acknowledge words. Reading one of these acknowledge words returns the vector number of the winning request. When the winner is a level-7 source, the same read clears that source's edge flag.

In low-power mode the controller raises a wakeup request when a pending level is above the wakeup mask. The hardware clamps that mask to at most 6, so a level-7 request can always wake the core.

Top module: `irq_prio_ctl`

## Requirements
- R1: After reset, irq_lvl and wake_req are 0, all mask bits read 1, the force register and the edge flags read 0, every control word reads 0, and the wakeup mask level reads 7.
- R2: A source whose control word level field (bits 5:3) is 0 never raises irq_lvl and never wins an acknowledge, even with its request high and its mask bit clear.
- R3: One cycle after its inputs, irq_lvl equals the highest level L among enabled, unmasked, pending sources when L is 7 or L is greater than cpu_ipl. Otherwise irq_lvl is 0, so requests of level 1 to 6 that are at or below cpu_ipl are held off.
- R4: A rising edge on the request of a level-7 source (the raw request ORed with the force bit) sets a sticky edge flag. Register word 2 reads these flags back, bit i for source i. The flag makes irq_lvl equal 7 even when cpu_ipl is 7, and it stays set after the request falls.
- R5: A read of level-acknowledge word 8+L (byte address 0x20+4L) returns 64+i, where i is the enabled, unmasked, pending source at level L with the highest priority field (bits 2:0). When two sources tie, the lower index wins. The processor level mask does not affect this read.
- R6: A read of the software acknowledge word 4 (byte address 0x10) returns 64+i for the highest level and priority among all enabled, unmasked, pending sources, with the same tie rule.
- R7: An acknowledge read with no eligible source returns the spurious vector 24. A level-0 acknowledge read always returns 24.
- R8: While sleep_en is 1, wake_req is 1 one cycle later if the highest eligible pending level exceeds the effective wakeup mask. The effective mask is the written 3-bit value (word 3) clamped to 6. With sleep_en at 0, wake_req is 0.
- R9: An edge flag is cleared by a write of 1 to its bit in word 2, but only after a read of word 2 returned that bit as 1. A write of 1 without that read has no effect. A write of 0 never has an effect. Each write to word 2 ends the armed state.
- R10: The force register (word 1) reads back what was written. Its bit i acts as a request on source i, ORed with the request input.
- R11: An acknowledge read whose winner is a level-7 source clears that source's edge flag at the same clock edge.
- R12: A source whose bit is 1 in the mask register (word 0) is ignored by irq_lvl, wake_req and both acknowledge reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | N_SRC | Request line per source |
| cpu_ipl | input | 3 | Current processor interrupt-level mask |
| sleep_en | input | 1 | Low-power mode active |
| bus_sel | input | 1 | Register access this cycle (word aligned; addresses with nonzero bits 1:0 are ignored) |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; word = bits 7:2; control word of source i at word 32+i |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read and held until the next read |
| irq_lvl | output | 3 | Requested interrupt level to the core, 0 = none |
| wake_req | output | 1 | Wakeup request in low-power mode |

## Verification
The checker watches, on every clock, that a level other than 7 is only requested when it is above the processor mask sampled one cycle earlier. It also checks that a wakeup never appears outside low-power mode, that every acknowledge read yields either the spurious vector or a vector inside the source range, and that a mask write lands in the mask register. The bench's scenarios are needed for the rest: which source wins a tie, the sticky level-7 edge and how an acknowledge clears it, the read-then-write-one clear sequence, the wakeup clamp, and the disabled reset state of a control word.

// File: rtl/icu_pkg.sv
`timescale 1ns/1ps
package icu_pkg;
  localparam logic [7:0] VEC_BASE = 8'd64;
  localparam logic [7:0] VEC_SPUR = 8'd24;

  localparam logic [5:0] W_MASK  = 6'd0;
  localparam logic [5:0] W_FORCE = 6'd1;
  localparam logic [5:0] W_EDGE  = 6'd2;
  localparam logic [5:0] W_WAKE  = 6'd3;
  localparam logic [5:0] W_SWACK = 6'd4;
  localparam logic [5:0] W_LACK  = 6'd8;
  localparam int unsigned W_CTRL = 32;

  typedef struct packed {
    logic [2:0] lvl;
    logic [2:0] pri;
  } src_cfg_t;
endpackage

// File: rtl/icu_src_bank.sv
`timescale 1ns/1ps
module icu_src_bank
  import icu_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC-1:0]     src_req,
  input  logic                 wr_mask,
  input  logic                 wr_force,
  input  logic                 wr_edge,
  input  logic                 rd_edge,
  input  logic [N_SRC-1:0]     wr_ctrl,
  input  logic [N_SRC-1:0]     wd_vec,
  input  src_cfg_t             wd_cfg,
  input  logic [N_SRC-1:0]     ack_clr,
  output src_cfg_t [N_SRC-1:0] cfg,
  output logic [N_SRC-1:0]     mask_q,
  output logic [N_SRC-1:0]     force_q,
  output logic [N_SRC-1:0]     eflag_q,
  output logic [N_SRC-1:0]     active
);
  logic [N_SRC-1:0] raw, prev_q, armed_q, is7, rise, clr;

  assign raw  = src_req | force_q;
  assign rise = raw & ~prev_q & is7;
  assign clr  = (wr_edge ? (wd_vec & armed_q) : '0) | ack_clr;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    src_cfg_t cfg_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cfg_r <= '0;
      else if (wr_ctrl[g]) cfg_r <= wd_cfg;
    end
    assign cfg[g]    = cfg_r;
    assign is7[g]    = (cfg_r.lvl == 3'd7);
    assign active[g] = (cfg_r.lvl != 3'd0) && (is7[g] ? eflag_q[g] : raw[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      force_q <= '0;
      eflag_q <= '0;
      armed_q <= '0;
      prev_q  <= '0;
    end else begin
      prev_q  <= raw;
      if (wr_mask)  mask_q  <= wd_vec;
      if (wr_force) force_q <= wd_vec;
      eflag_q <= (eflag_q & ~clr) | rise;
      if (wr_edge)      armed_q <= '0;
      else if (rd_edge) armed_q <= (armed_q | eflag_q) & ~ack_clr;
      else              armed_q <= armed_q & ~ack_clr;
    end
  end
endmodule

// File: rtl/icu_pri_pick.sv
`timescale 1ns/1ps
module icu_pri_pick
  import icu_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]     cand,
  input  src_cfg_t [N_SRC-1:0] cfg,
  output logic                 found,
  output logic [IDX_W-1:0]     idx,
  output logic [2:0]           lvl
);
  logic [5:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    lvl   = 3'd0;
    best  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i] && (!found || ({cfg[i].lvl, cfg[i].pri} > best))) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        lvl   = cfg[i].lvl;
        best  = {cfg[i].lvl, cfg[i].pri};
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctl.sv
`timescale 1ns/1ps
module irq_prio_ctl
  import icu_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic [2:0]       cpu_ipl,
  input  logic             sleep_en,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [2:0]       irq_lvl,
  output logic             wake_req
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [5:0] word;
  logic       acc, rd_req, wr_req, is_sw, is_lack;
  logic [2:0] ack_lvl, wake_q, wake_eff;

  src_cfg_t [N_SRC-1:0] cfg;
  logic [N_SRC-1:0] mask_q, force_q, eflag_q, active, elig;
  logic [N_SRC-1:0] ack_cand, ack_clr, wr_ctrl;

  logic             g_found, a_found;
  logic [IDX_W-1:0] g_idx, a_idx;
  logic [2:0]       g_lvl, a_lvl;
  logic [31:0]      rd_val;

  assign word    = bus_addr[7:2];
  assign acc     = bus_sel && (bus_addr[1:0] == 2'b00);
  assign rd_req  = acc && !bus_wr;
  assign wr_req  = acc && bus_wr;
  assign is_sw   = (word == W_SWACK);
  assign is_lack = (word[5:3] == W_LACK[5:3]);
  assign ack_lvl = word[2:0];

  assign elig = active & ~mask_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_dec
    localparam logic [5:0] WI = 6'(W_CTRL + g);
    assign wr_ctrl[g]  = wr_req && (word == WI);
    assign ack_cand[g] = elig[g] && (is_sw || (is_lack && (cfg[g].lvl == ack_lvl)));
  end

  icu_src_bank #(.N_SRC(N_SRC)) bank_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_req (src_req),
    .wr_mask (wr_req && (word == W_MASK)),
    .wr_force(wr_req && (word == W_FORCE)),
    .wr_edge (wr_req && (word == W_EDGE)),
    .rd_edge (rd_req && (word == W_EDGE)),
    .wr_ctrl (wr_ctrl),
    .wd_vec  (bus_wdata[N_SRC-1:0]),
    .wd_cfg  (bus_wdata[5:0]),
    .ack_clr (ack_clr),
    .cfg     (cfg),
    .mask_q  (mask_q),
    .force_q (force_q),
    .eflag_q (eflag_q),
    .active  (active)
  );

  icu_pri_pick #(.N_SRC(N_SRC)) glob_pick_i (
    .cand (elig),
    .cfg  (cfg),
    .found(g_found),
    .idx  (g_idx),
    .lvl  (g_lvl)
  );

  icu_pri_pick #(.N_SRC(N_SRC)) ack_pick_i (
    .cand (ack_cand),
    .cfg  (cfg),
    .found(a_found),
    .idx  (a_idx),
    .lvl  (a_lvl)
  );

  always_comb begin
    ack_clr = '0;
    if (rd_req && (is_sw || is_lack) && a_found && (a_lvl == 3'd7))
      ack_clr[a_idx] = 1'b1;
  end

  assign wake_eff = (wake_q == 3'd7) ? 3'd6 : wake_q;

  always_comb begin
    rd_val = '0;
    if (word == W_MASK)       rd_val[N_SRC-1:0] = mask_q;
    else if (word == W_FORCE) rd_val[N_SRC-1:0] = force_q;
    else if (word == W_EDGE)  rd_val[N_SRC-1:0] = eflag_q;
    else if (word == W_WAKE)  rd_val[2:0] = wake_q;
    else if (is_sw || is_lack)
      rd_val[7:0] = a_found ? (VEC_BASE + 8'(g_idx_unused_guard(a_idx))) : VEC_SPUR;
    for (int i = 0; i < N_SRC; i++)
      if (word == 6'(W_CTRL + i)) rd_val[5:0] = cfg[i];
  end

  function automatic logic [7:0] g_idx_unused_guard(input logic [IDX_W-1:0] v);
    return 8'(v);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q    <= 3'd7;
      irq_lvl   <= 3'd0;
      wake_req  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_req && (word == W_WAKE)) wake_q <= bus_wdata[2:0];
      irq_lvl  <= (g_found && ((g_lvl == 3'd7) || (g_lvl > cpu_ipl))) ? g_lvl : 3'd0;
      wake_req <= sleep_en && g_found && (g_lvl > wake_eff);
      if (rd_req) bus_rdata <= rd_val;
    end
  end

  logic unused_g_idx;
  assign unused_g_idx = ^g_idx;
endmodule

// File: rtl/irq_prio_ctl_chk.sv
`timescale 1ns/1ps
module irq_prio_ctl_chk #(
  parameter int unsigned N_SRC = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cpu_ipl,
  input logic             sleep_en,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic [2:0]       irq_lvl,
  input logic             wake_req,
  input logic [N_SRC-1:0] mask_q
);
  logic ack_rd, mask_wr;
  assign ack_rd  = bus_sel && !bus_wr && (bus_addr[1:0] == 2'b00) &&
                   ((bus_addr[7:2] == 6'd4) || (bus_addr[7:5] == 3'b001));
  assign mask_wr = bus_sel && bus_wr && (bus_addr == 8'h00);

  // R3: a level below 7 is only requested when above the processor mask
  a_r3_lvl_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_lvl != 3'd0) && (irq_lvl != 3'd7)) |-> (irq_lvl > $past(cpu_ipl)));

  // R8: wakeup only in low-power mode
  a_r8_wake_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(sleep_en));

  // R7: acknowledge reads give the spurious vector or a source vector
  a_r7_ack_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd |=> ((bus_rdata == 32'd24) ||
                ((bus_rdata >= 32'd64) && (bus_rdata < 32'(64 + N_SRC)))));

  // R12: a mask write lands in the mask register
  a_r12_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(bus_wdata[N_SRC-1:0])));
endmodule

bind irq_prio_ctl irq_prio_ctl_chk #(.N_SRC(N_SRC)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_ipl  (cpu_ipl),
  .sleep_en (sleep_en),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq_lvl  (irq_lvl),
  .wake_req (wake_req),
  .mask_q   (mask_q)
);

// File: tb/irq_prio_ctl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctl_tb_top;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src_req = '0;
  logic [2:0]  cpu_ipl = 3'd0;
  logic        sleep_en = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_lvl;
  logic        wake_req;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  irq_prio_ctl #(.N_SRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .cpu_ipl(cpu_ipl),
    .sleep_en(sleep_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lvl(irq_lvl), .wake_req(wake_req)
  );

  // ---------------- reference model ----------------
  int        m_lvl[N], m_pri[N];
  bit [31:0] m_mask, m_force, m_ef, m_arm, m_prev;
  int        m_wake;
  int        exp_irq, exp_wake;
  bit [31:0] exp_rd;

  function automatic void best_of(input bit [31:0] cand, output int idx, output int lv);
    int key = -1;
    idx = -1; lv = 0;
    for (int i = 0; i < N; i++)
      if (cand[i] && (m_lvl[i] * 8 + m_pri[i] > key)) begin
        key = m_lvl[i] * 8 + m_pri[i]; idx = i; lv = m_lvl[i];
      end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_lvl[i] = 0; m_pri[i] = 0; end
      m_mask = '1; m_force = '0; m_ef = '0; m_arm = '0; m_prev = '0;
      m_wake = 7; exp_irq = 0; exp_wake = 0; exp_rd = '0;
    end else begin
      bit [31:0] raw, act, elig, cand, clr, rise;
      int gi, gl, ai, al, w, weff;
      bit rd, wr;
      raw = src_req | m_force;
      for (int i = 0; i < N; i++)
        act[i] = (m_lvl[i] != 0) && ((m_lvl[i] == 7) ? m_ef[i] : raw[i]);
      elig = act & ~m_mask;
      best_of(elig, gi, gl);
      rd = bus_sel && !bus_wr && (bus_addr[1:0] == 0);
      wr = bus_sel && bus_wr && (bus_addr[1:0] == 0);
      w  = bus_addr[7:2];
      clr = '0;
      weff = (m_wake > 6) ? 6 : m_wake;
      exp_irq  = (gi >= 0 && (gl == 7 || gl > cpu_ipl)) ? gl : 0;
      exp_wake = (sleep_en && gi >= 0 && gl > weff) ? 1 : 0;
      if (rd) begin
        if (w == 0) exp_rd = m_mask;
        else if (w == 1) exp_rd = m_force;
        else if (w == 2) begin exp_rd = m_ef; m_arm = m_arm | m_ef; end
        else if (w == 3) exp_rd = m_wake;
        else if (w == 4 || (w >= 8 && w <= 15)) begin
          for (int i = 0; i < N; i++) cand[i] = elig[i] && (w == 4 || m_lvl[i] == w - 8);
          best_of(cand, ai, al);
          exp_rd = (ai < 0) ? 24 : 64 + ai;
          if (ai >= 0 && al == 7) begin clr[ai] = 1; m_arm[ai] = 0; end
        end else if (w >= 32 && w < 32 + N) exp_rd = m_lvl[w-32] * 8 + m_pri[w-32];
        else exp_rd = 0;
      end
      for (int i = 0; i < N; i++) rise[i] = raw[i] && !m_prev[i] && (m_lvl[i] == 7);
      if (wr) begin
        if (w == 0) m_mask = bus_wdata;
        else if (w == 1) m_force = bus_wdata;
        else if (w == 2) begin clr = clr | (bus_wdata & m_arm); m_arm = '0; end
        else if (w == 3) m_wake = bus_wdata[2:0];
        else if (w >= 32 && w < 32 + N) begin
          m_lvl[w-32] = bus_wdata[5:3]; m_pri[w-32] = bus_wdata[2:0];
        end
      end
      m_ef = (m_ef & ~clr) | rise;
      m_prev = raw;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (irq_lvl !== 3'(exp_irq) || wake_req !== exp_wake[0] || bus_rdata !== exp_rd) begin
        mismatched++;
        $display("FAIL %s model: irq=%0d/%0d wake=%0d/%0d rdata=%0h/%0h (actual/expected)",
                 tag, irq_lvl, exp_irq, wake_req, exp_wake, bus_rdata, exp_rd);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string t, input logic [31:0] got, input logic [31:0] expv);
    compared++;
    if (got !== expv) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", t, got, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    idle(3); rst_n = 1; idle(2);
    tag = "R1";
    chk("R1 irq after reset", {29'b0, irq_lvl}, 0);
    rd(8'h00, v); chk("R1 mask reset", v, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk("R1 wake level reset", v, 7);
    rd(8'h80, v); chk("R1 ctrl reset", v, 0);

    tag = "R2";
    wr(8'h00, 0); src_req = '1; idle(3);
    chk("R2 disabled sources no irq", {29'b0, irq_lvl}, 0);
    rd(8'h10, v); chk("R2 disabled sources no ack", v, 24);
    src_req = '0;

    tag = "R3";
    wr(8'h8C, 32'h22); wr(8'h94, 32'h10);
    src_req[3] = 1; src_req[5] = 1; idle(3);
    chk("R3 level 4 above ipl 0", {29'b0, irq_lvl}, 4);
    cpu_ipl = 4; idle(2);
    chk("R3 held at ipl 4", {29'b0, irq_lvl}, 0);
    cpu_ipl = 3; idle(2);
    chk("R3 level 4 above ipl 3", {29'b0, irq_lvl}, 4);

    tag = "R5";
    wr(8'hA4, 32'h22); src_req[9] = 1; idle(1);
    rd(8'h30, v); chk("R5 tie lower index", v, 67);
    wr(8'hA8, 32'h25); src_req[10] = 1; idle(1);
    rd(8'h30, v); chk("R5 higher priority", v, 74);
    rd(8'h28, v); chk("R5 level 2 ack", v, 69);

    tag = "R6";
    rd(8'h10, v); chk("R6 software ack", v, 74);

    tag = "R7";
    rd(8'h34, v); chk("R7 empty level spurious", v, 24);
    rd(8'h20, v); chk("R7 level 0 spurious", v, 24);

    tag = "R12";
    wr(8'h00, 32'h400); idle(1);
    rd(8'h30, v); chk("R12 masked source skipped", v, 67);
    rd(8'h10, v); chk("R12 masked sw ack", v, 67);

    tag = "R4";
    wr(8'hD0, 32'h38); cpu_ipl = 7;
    @(negedge clk); src_req[20] = 1; @(negedge clk); src_req[20] = 0;
    idle(3);
    chk("R4 sticky level 7 irq", {29'b0, irq_lvl}, 7);
    rd(8'h08, v); chk("R4 edge flag set", v, 32'h0010_0000);

    tag = "R11";
    rd(8'h3C, v); chk("R11 level 7 ack vector", v, 84);
    idle(2);
    chk("R11 irq cleared", {29'b0, irq_lvl}, 0);
    rd(8'h08, v); chk("R11 flag cleared", v, 0);

    tag = "R9";
    @(negedge clk); src_req[20] = 1; @(negedge clk); src_req[20] = 0;
    idle(1);
    wr(8'h08, 32'h0010_0000);
    rd(8'h08, v); chk("R9 write one without read", v, 32'h0010_0000);
    wr(8'h08, 0);
    rd(8'h08, v); chk("R9 write zero no effect", v, 32'h0010_0000);
    wr(8'h08, 32'h0010_0000);
    rd(8'h08, v); chk("R9 read then write one clears", v, 0);

    tag = "R10";
    src_req = '0; cpu_ipl = 0;
    wr(8'h04, 32'h20); idle(1);
    rd(8'h04, v); chk("R10 force readback", v, 32'h20);
    idle(2);
    chk("R10 forced source raises level", {29'b0, irq_lvl}, 2);

    tag = "R8";
    sleep_en = 1; idle(3);
    chk("R8 level 2 below clamped mask", {31'b0, wake_req}, 0);
    wr(8'h04, 32'h0010_0020); idle(3);
    chk("R8 level 7 wakes through clamp", {31'b0, wake_req}, 1);
    rd(8'h3C, v); chk("R8 ack level 7", v, 84);
    idle(2);
    chk("R8 no wake after ack", {31'b0, wake_req}, 0);
    wr(8'h0C, 1); idle(2);
    chk("R8 wake above mask 1", {31'b0, wake_req}, 1);
    wr(8'h0C, 2); idle(2);
    chk("R8 no wake at mask 2", {31'b0, wake_req}, 0);
    sleep_en = 0; wr(8'h0C, 0); idle(2);
    chk("R8 no wake outside sleep", {31'b0, wake_req}, 0);

    idle(2);
    summary();
  end
endmodule